// File: doc/BRIEF.md
# Pipelined ADC Digital Back End

This block sits behind the analog stages of a four-stage pipelined analog-to-digital converter. The first three stages each resolve a 4-bit code that carries one bit of overlap with the next stage. The fourth stage is a plain 4-bit flash. Neighbouring stages work on opposite clock phases, so the four codes that belong to one analog sample reach the block half a clock apart. The block lines those codes up in time. It then merges them into one word, and the overlap absorbs decision errors of one step in the earlier stages. The merged word is clamped to 12 bits and delivered in offset binary through a two-deep register pair on the rising clock edge.

The stage codes share one flat input bus. A strobe travels with the first-stage code to mark the slots that carry real samples. Results come out at one per clock with a fixed latency, and a valid flag marks them.

Top module: `pipe_adc_backend`

## Requirements
- R1: While `rst_n` is low, `result` is 0 and `result_valid` is 0, whatever the inputs do. They stay at 0 after release until the first valid sample has passed through.
- R2: The stage-1 code and `smp_valid` of a sample are captured on rising edge n. Its word appears on `result` after rising edge n+3, and `result_valid` is high for exactly that cycle. `result_valid` tracks `smp_valid` with this three-cycle delay.
- R3: Stage k (k = 1..4) of a sample is presented on lane k-1 of `stage_codes`, which is bits [4(k-1)+3 : 4(k-1)]. Lane k-1 is sampled k-1 half cycles after stage 1. Stages 1 and 3 are taken on rising edges n and n+1. Stages 2 and 4 are taken on falling edges n+1/2 and n+3/2.
- R4: The word is S - 584, where S = B1*512 + B2*64 + B3*8 + B4 and Bk is the unsigned code of stage k.
- R5: An error of +1 or -1 in stage k (k = 1..3), offset by a change of -8 or +8 in stage k+1's code, gives the same word as the ideal codes.
- R6: When S - 584 is below 0, the word is 12'h000.
- R7: When S - 584 is above 4095, the word is 12'hFFF.
- R8: Valid samples may arrive on every clock, and each one yields its own result on consecutive cycles.
- R9: A slot with `smp_valid` low yields `result_valid` low, and `result` keeps the last word delivered. The stage codes in that slot have no effect.
- R10: The output is offset binary with bit 11 as the MSB. Input 0 gives 12'h000, mid-scale 2048 gives 12'h800, and full scale 4095 gives 12'hFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; both edges capture stage codes |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| smp_valid | input | 1 | Marks a real sample; travels with the stage-1 code |
| stage_codes | input | 16 | Four 4-bit stage codes, stage 1 in the low lane |
| result | output | 12 | Corrected, clamped offset-binary word |
| result_valid | output | 1 | High in the cycle a new word is on `result` |

## Verification
The assertions check on every cycle that the valid flag trails the input strobe by exactly three cycles. They also check that the output word holds in idle slots, that out-of-range sums saturate high or low, and that reset clears the outputs. Only the bench scenarios show the rest. Those are the exact arithmetic value, the cancellation of injected one-step stage errors, and the half-cycle staggering of the four lanes. They also include the back-to-back throughput, which is checked against words computed from known sample values.

// File: rtl/pab_pkg.sv
package pab_pkg;

  // Sum of the half-step shifts added by the redundant bit of each
  // non-final stage; removed once from the merged sum.
  function automatic int unsigned corr_offset(int unsigned n_stages, int unsigned step_w);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i + 1 < n_stages; i++) begin
      acc = acc + (32'd1 << (step_w * (n_stages - 1 - i)));
    end
    return acc;
  endfunction

  // Weight (as a left shift) of stage i in the merged sum.
  function automatic int unsigned lane_shift(int unsigned n_stages, int unsigned step_w,
                                             int unsigned i);
    return step_w * (n_stages - 1 - i);
  endfunction

  // Odd-numbered lanes (stages 2, 4, ...) work on the opposite phase.
  function automatic bit falling_capture(int unsigned i);
    return (i % 2) == 1;
  endfunction

  // Rising-edge cycle at which lane i becomes available after capture
  // (and retiming for falling lanes) is ceil(i/2); the last lane sets
  // the alignment point n_stages/2.
  function automatic int unsigned align_depth(int unsigned n_stages, int unsigned i);
    return (n_stages / 2) - ((i + 1) / 2);
  endfunction

endpackage

// File: rtl/pab_rst_sync.sv
module pab_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pab_stage_capture.sv
module pab_stage_capture #(
  parameter int unsigned W       = 4,
  parameter bit          FALLING = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] code_rise
);

  generate
    if (FALLING) begin : g_fall
      logic [W-1:0] neg_q;
      logic [W-1:0] ret_q;

      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
          neg_q <= '0;
        end else begin
          neg_q <= code_in;
        end
      end

      // Move the half-cycle-late capture onto the common rising edge.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ret_q <= '0;
        end else begin
          ret_q <= neg_q;
        end
      end

      assign code_rise = ret_q;
    end else begin : g_rise
      logic [W-1:0] pos_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pos_q <= '0;
        end else begin
          pos_q <= code_in;
        end
      end

      assign code_rise = pos_q;
    end
  endgenerate

endmodule

// File: rtl/pab_delay.sv
module pab_delay #(
  parameter int unsigned W     = 4,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_pipe
      logic [W-1:0] pipe_q [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < DEPTH; k++) begin
            pipe_q[k] <= '0;
          end
        end else begin
          pipe_q[0] <= din;
          for (int k = 1; k < DEPTH; k++) begin
            pipe_q[k] <= pipe_q[k-1];
          end
        end
      end

      assign dout = pipe_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/pab_corrector.sv
module pab_corrector
  import pab_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned STEP_W     = 3,
  parameter int unsigned OUT_W      = 12
) (
  input  logic [NUM_STAGES*CODE_W-1:0] codes,
  output logic [OUT_W-1:0]             value
);

  // Two guard bits: one for the carry headroom, one for the sign.
  localparam int unsigned SUM_W = CODE_W + STEP_W * (NUM_STAGES - 1) + 2;
  localparam logic [SUM_W-1:0] OFFSET = SUM_W'(corr_offset(NUM_STAGES, STEP_W));

  logic [SUM_W-1:0] acc;
  logic             below;
  logic             above;

  always_comb begin
    acc = '0 - OFFSET;
    for (int unsigned i = 0; i < NUM_STAGES; i++) begin
      acc = acc + (SUM_W'(codes[i*CODE_W +: CODE_W]) << lane_shift(NUM_STAGES, STEP_W, i));
    end
  end

  assign below = acc[SUM_W-1];
  assign above = !below && (acc[SUM_W-2:OUT_W] != '0);

  always_comb begin
    if (below) begin
      value = '0;
    end else if (above) begin
      value = '1;
    end else begin
      value = acc[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/pipe_adc_backend.sv
module pipe_adc_backend
  import pab_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned STEP_W     = 3,
  parameter int unsigned OUT_W      = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         smp_valid,
  input  logic [NUM_STAGES*CODE_W-1:0] stage_codes,
  output logic [OUT_W-1:0]             result,
  output logic                         result_valid
);

  localparam int unsigned BUS_W = NUM_STAGES * CODE_W;

  logic             rst_sync_n;
  logic [BUS_W-1:0] aligned_codes;
  logic             valid_rise;
  logic             aligned_valid;
  logic [OUT_W-1:0] corr_value;

  logic [OUT_W-1:0] result_q;
  logic [OUT_W-1:0] result_d;
  logic             valid_q;
  logic             valid_d;

  pab_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Per-lane capture on the lane's phase, then delay to the common point.
  for (genvar gi = 0; gi < NUM_STAGES; gi++) begin : g_stage
    logic [CODE_W-1:0] rise_code;

    pab_stage_capture #(
      .W       (CODE_W),
      .FALLING (falling_capture(gi))
    ) u_cap (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .code_in   (stage_codes[gi*CODE_W +: CODE_W]),
      .code_rise (rise_code)
    );

    pab_delay #(
      .W     (CODE_W),
      .DEPTH (align_depth(NUM_STAGES, gi))
    ) u_dly (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .din   (rise_code),
      .dout  (aligned_codes[gi*CODE_W +: CODE_W])
    );
  end

  // The strobe follows the first lane exactly.
  pab_stage_capture #(
    .W       (1),
    .FALLING (1'b0)
  ) u_vcap (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .code_in   (smp_valid),
    .code_rise (valid_rise)
  );

  pab_delay #(
    .W     (1),
    .DEPTH (align_depth(NUM_STAGES, 0))
  ) u_vdly (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (valid_rise),
    .dout  (aligned_valid)
  );

  pab_corrector #(
    .NUM_STAGES (NUM_STAGES),
    .CODE_W     (CODE_W),
    .STEP_W     (STEP_W),
    .OUT_W      (OUT_W)
  ) u_corr (
    .codes (aligned_codes),
    .value (corr_value)
  );

  // Second buffer: load only on a real sample, otherwise hold.
  always_comb begin
    result_d = result_q;
    valid_d  = aligned_valid;
    if (aligned_valid) begin
      result_d = corr_value;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      result_q <= result_d;
      valid_q  <= valid_d;
    end
  end

  assign result       = result_q;
  assign result_valid = valid_q;

endmodule

// File: rtl/pipe_adc_backend_chk.sv
module pipe_adc_backend_chk
  import pab_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned STEP_W     = 3,
  parameter int unsigned OUT_W      = 12
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         rst_int_n,
  input logic                         smp_valid,
  input logic [NUM_STAGES*CODE_W-1:0] aligned_codes,
  input logic                         aligned_valid,
  input logic [OUT_W-1:0]             result,
  input logic                         result_valid
);

  localparam int unsigned LAT    = NUM_STAGES / 2 + 1;
  localparam int unsigned OFF    = corr_offset(NUM_STAGES, STEP_W);
  localparam int unsigned HI_LIM = OFF + (32'd1 << OUT_W) - 1;

  // Shadow of the input strobe, one stage deeper than the latency
  // because properties sample the pre-edge value.
  logic [LAT:0] vshadow_q;
  int unsigned  chk_sum;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vshadow_q <= '0;
    end else begin
      vshadow_q <= {vshadow_q[LAT-1:0], smp_valid};
    end
  end

  always_comb begin
    chk_sum = 0;
    for (int unsigned i = 0; i < NUM_STAGES; i++) begin
      chk_sum = chk_sum + (32'(aligned_codes[i*CODE_W +: CODE_W]) << lane_shift(NUM_STAGES, STEP_W, i));
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (result == '0 && !result_valid)
        else $error("R1: outputs not cleared during reset");
    end
  end

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    result_valid == vshadow_q[LAT])
    else $error("R2: result_valid does not trail smp_valid by the latency");

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !result_valid |-> $stable(result))
    else $error("R9: result changed in an idle slot");

  assert_clamp_low_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (aligned_valid && chk_sum < OFF) |=> (result == '0))
    else $error("R6: negative sum not clamped to zero");

  assert_clamp_high_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (aligned_valid && chk_sum > HI_LIM) |=> (result == '1))
    else $error("R7: oversized sum not clamped to full scale");

endmodule

bind pipe_adc_backend pipe_adc_backend_chk #(
  .NUM_STAGES (NUM_STAGES),
  .CODE_W     (CODE_W),
  .STEP_W     (STEP_W),
  .OUT_W      (OUT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rst_int_n     (rst_sync_n),
  .smp_valid     (smp_valid),
  .aligned_codes (aligned_codes),
  .aligned_valid (aligned_valid),
  .result        (result),
  .result_valid  (result_valid)
);

// File: tb/tb_pipe_adc_backend.sv
`timescale 1ns/1ps
module tb_pipe_adc_backend;

  localparam int NSMP = 600;

  logic        clk;
  logic        rst_n;
  logic        smp_valid;
  logic [15:0] stage_codes;
  logic [11:0] result;
  logic        result_valid;

  logic [3:0]  cq [NSMP][4];
  bit          vq [NSMP];
  logic [11:0] eq [NSMP];
  string       tq [NSMP];

  int          checks;
  int          errors;
  bit          done;
  logic [11:0] last_exp;
  int          cur_run;
  int          best_run;

  pipe_adc_backend dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_valid    (smp_valid),
    .stage_codes  (stage_codes),
    .result       (result),
    .result_valid (result_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Word expected from raw codes by the formula of R4, R6 and R7.
  function automatic logic [11:0] ref_fix(int b0, int b1, int b2, int b3);
    int s;
    s = b0 * 512 + b1 * 64 + b2 * 8 + b3 - 584;
    if (s < 0) return 12'h000;
    if (s > 4095) return 12'hFFF;
    return 12'(s);
  endfunction

  // Ideal stage codes for sample x; err_stage 1..3 injects a one-step
  // error there, offset by a change of eight in the next stage (R5).
  task automatic put_ideal(int idx, int x, int err_stage, string tag);
    int b[4];
    int r;
    b[0] = (x >> 9) + 1;  r = x - ((b[0] - 1) << 9);
    b[1] = (r >> 6) + 1;  r = r - ((b[1] - 1) << 6);
    b[2] = (r >> 3) + 1;  r = r - ((b[2] - 1) << 3);
    b[3] = r;
    if (err_stage >= 1 && err_stage <= 3) begin
      if (b[err_stage] >= 8) begin
        b[err_stage-1] += 1;  b[err_stage] -= 8;
      end else begin
        b[err_stage-1] -= 1;  b[err_stage] += 8;
      end
    end
    for (int s = 0; s < 4; s++) cq[idx][s] = 4'(b[s]);
    vq[idx] = 1'b1;
    eq[idx] = 12'(x);
    tq[idx] = tag;
  endtask

  task automatic put_raw(int idx, int b0, int b1, int b2, int b3, string tag);
    cq[idx][0] = 4'(b0); cq[idx][1] = 4'(b1);
    cq[idx][2] = 4'(b2); cq[idx][3] = 4'(b3);
    vq[idx] = 1'b1;
    eq[idx] = ref_fix(b0, b1, b2, b3);
    tq[idx] = tag;
  endtask

  task automatic put_idle(int idx);
    for (int s = 0; s < 4; s++) cq[idx][s] = 4'($urandom);
    vq[idx] = 1'b0;
    eq[idx] = 12'h000;
    tq[idx] = "R9";
  endtask

  function automatic logic [3:0] code_at(int stage, int idx);
    if (idx < 0 || idx >= NSMP) return 4'h0;
    return cq[idx][stage];
  endfunction

  // In the window after rising edge j: stage 1 of sample j+1, stages 2
  // and 3 of sample j, stage 4 of sample j-1 (half-cycle stagger, R3).
  task automatic drive(int j);
    stage_codes = {code_at(3, j - 1), code_at(2, j), code_at(1, j), code_at(0, j + 1)};
    smp_valid   = (j + 1 >= 0 && j + 1 < NSMP) ? vq[j + 1] : 1'b0;
  endtask

  task automatic check_sample(int n);
    if (vq[n]) begin
      chk("R2 result_valid at latency", result_valid, 1);
      chk(tq[n], result, eq[n]);
      last_exp = eq[n];
      cur_run++;
      if (cur_run > best_run) best_run = cur_run;
    end else begin
      chk("R9 result_valid low in idle slot", result_valid, 0);
      chk("R9 result held in idle slot", result, last_exp);
      cur_run = 0;
    end
  endtask

  task automatic build();
    put_ideal(0, 0, 0, "R10 zero input");
    put_ideal(1, 4095, 0, "R10 full scale");
    put_ideal(2, 2048, 0, "R10 mid scale");
    put_raw(3, 1, 1, 0, 7, "R6 sum one below offset");
    put_raw(4, 0, 0, 0, 0, "R6 all-zero codes");
    put_raw(5, 8, 8, 8, 8, "R7 one above full scale");
    put_raw(6, 15, 15, 15, 15, "R7 all-ones codes");
    put_idle(7);
    put_idle(8);
    put_ideal(9, 1234, 1, "R5 stage 1 error");
    put_ideal(10, 1234, 2, "R5 stage 2 error");
    put_ideal(11, 1234, 3, "R5 stage 3 error");
    put_ideal(12, 0, 1, "R5 stage 1 low error at zero");
    put_ideal(13, 4095, 1, "R5 stage 1 high error at full scale");
    put_idle(14);
    put_ideal(15, 1000, 0, "R3 lane alignment a");
    put_ideal(16, 3000, 0, "R3 lane alignment b");
    for (int idx = 17; idx < NSMP; idx++) begin
      if ($urandom % 8 == 0) begin
        put_idle(idx);
      end else begin
        int x;
        int e;
        x = int'($urandom % 4096);
        e = int'($urandom % 4);
        put_ideal(idx, x, e, (e == 0) ? "R4 random sample" : "R5 random stage error");
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    last_exp = 12'h000; cur_run = 0; best_run = 0;
    void'($urandom(32'd7321));
    rst_n       = 1'b0;
    smp_valid   = 1'b1;
    stage_codes = 16'hA5C3;
    build();

    repeat (4) @(posedge clk);
    #1;
    chk("R1 result in reset", result, 0);
    chk("R1 result_valid in reset", result_valid, 0);
    smp_valid   = 1'b0;
    stage_codes = 16'h0000;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk("R1 result after release", result, 0);
    chk("R1 result_valid after release", result_valid, 0);

    drive(-1);
    for (int j = 0; j < NSMP + 4; j++) begin
      @(posedge clk);
      #1;
      if (j >= 3 && j - 3 < NSMP) check_sample(j - 3);
      drive(j);
    end

    chk("R8 back-to-back results", (best_run >= 7) ? 1 : 0, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule